// File: doc/BRIEF.md
# Timer Interrupt Flag Controller

This block keeps the event flags of an eight-channel capture/compare timer and its counter-overflow flag. It places them on a small byte-wide register bus. Each channel event and each overflow arrives as a one-cycle pulse, and that pulse latches the matching flag. Software reads the flags at any time. It clears a flag by writing a one to that flag's bit. This write-one-to-clear works only while the timer enable or the pulse-accumulator enable is high.

A fast-clear mode lets the capture/compare data accesses clear flags without a separate write. A read of a capture channel's data register clears that channel's flag. A write to a compare channel's data register clears that channel's flag. One combined interrupt request goes out from the flags, masked by per-flag enables. The counter, the capture/compare datapaths and the interrupt controller sit outside this block.

Top module: `tflg_ctrl`

## Requirements
- R1: After reset, every channel flag and the overflow flag are 0 and `irq_o` is 0.
- R2: The read data is combinational from `addr_i`. Address 0x0E returns channel flag n in bit n. Address 0x0F returns the overflow flag in bit 7, with bits 6:0 always 0. Every other address returns 0.
- R3: A pulse on `ch_evt_i[n]` sets channel flag n at the next clock edge. A pulse on `ovf_evt_i` sets the overflow flag at the next clock edge.
- R4: While `tmr_en_i` or `pacc_en_i` is high, these writes clear flags at the next edge:
  - a write to 0x0E clears every channel flag whose data bit is 1;
  - a write to 0x0F with bit 7 set clears the overflow flag.
  Data bits that are 0 leave their flags unchanged, and bits 6:0 at 0x0F have no effect.
- R5: While `tmr_en_i` and `pacc_en_i` are both low, writes to 0x0E and 0x0F change no flag.
- R6: While `fast_clr_i` is high, an access in 0x10..0x1F addresses channel `addr_i[3:1]`. This holds for both bytes of the channel's pair. The access clears that channel's flag in two cases:
  - a read (`rd_i`) when `ch_is_cmp_i[n]` is 0 (capture);
  - a write (`wr_i`) when `ch_is_cmp_i[n]` is 1 (compare).
  The opposite access direction clears nothing. This clearing does not depend on the enables.
- R7: While `fast_clr_i` is low, accesses in 0x10..0x1F change no flag.
- R8: If a set pulse and any clear request hit the same flag in the same cycle, the flag is 1 after the edge.
- R9: `irq_o` is high exactly when some channel flag n and `ch_irq_en_i[n]` are both 1, or when the overflow flag and `ovf_irq_en_i` are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 5 | Register byte address |
| rd_i | input | 1 | Read strobe, one cycle per access |
| wr_i | input | 1 | Write strobe, one cycle per access |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for `addr_i` |
| ch_evt_i | input | 8 | Per-channel capture/compare event pulses |
| ovf_evt_i | input | 1 | Counter overflow pulse |
| tmr_en_i | input | 1 | Timer enable, permits write-one-to-clear |
| pacc_en_i | input | 1 | Pulse accumulator enable, permits write-one-to-clear |
| fast_clr_i | input | 1 | Fast-clear mode select |
| ch_is_cmp_i | input | 8 | Per-channel mode: 1 compare, 0 capture |
| ch_irq_en_i | input | 8 | Per-channel interrupt enables |
| ovf_irq_en_i | input | 1 | Overflow interrupt enable |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The bench builds the block with its defaults: eight channels, a five-bit address and byte-wide data. With these values the channel flags fill the whole flag byte, and the fast-clear window covers 0x10 to 0x1F. Every channel index and both bytes of each channel's pair can therefore be reached. Random addresses also land on unmapped locations, so the zero read-back and the absence of side effects there are exercised alongside the mapped registers.

// File: rtl/tflg_pkg.sv
package tflg_pkg;
  localparam int FLG_OFF  = 14;  // channel flag byte
  localparam int OVF_OFF  = 15;  // overflow flag byte
  localparam int WIN_BASE = 16;  // first capture/compare data byte

  typedef struct packed {
    logic rd;
    logic wr;
  } bus_op_t;
endpackage

// File: rtl/tflg_decode.sv
module tflg_decode #(
  parameter int NCH = 8,
  parameter int AW  = 5,
  parameter int DW  = 8
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [AW-1:0]         addr_i,
  input  tflg_pkg::bus_op_t     op_i,
  input  logic [DW-1:0]         wdata_i,
  input  logic                  tmr_en_i,
  input  logic                  pacc_en_i,
  input  logic                  fast_clr_i,
  input  logic [NCH-1:0]        ch_is_cmp_i,
  output logic                  sel_flg_o,
  output logic                  sel_ovf_o,
  output logic [NCH-1:0]        ch_clr_o,
  output logic                  ovf_clr_o
);
  import tflg_pkg::*;

  localparam int WIN_END = WIN_BASE + 2 * NCH;

  logic [31:0]    a32;
  logic           in_win;
  logic [AW-1:0]  win_off;
  logic [AW-1:0]  win_ch;
  logic           w1c_ok;
  logic           w1c_flg;
  logic [NCH-1:0] fc_hit;

  assign a32       = 32'(addr_i);
  assign sel_flg_o = (a32 == 32'(FLG_OFF));
  assign sel_ovf_o = (a32 == 32'(OVF_OFF));
  assign in_win    = (a32 >= 32'(WIN_BASE)) && (a32 < 32'(WIN_END));
  assign win_off   = addr_i - AW'(WIN_BASE);
  assign win_ch    = win_off >> 1;  // two bytes per channel

  assign w1c_ok  = tmr_en_i | pacc_en_i;
  assign w1c_flg = op_i.wr & sel_flg_o & w1c_ok;

  for (genvar i = 0; i < NCH; i++) begin : g_fc
    // capture clears on read, compare clears on write
    assign fc_hit[i] = fast_clr_i & in_win & (win_ch == AW'(i)) &
                       (ch_is_cmp_i[i] ? op_i.wr : op_i.rd);
    assign ch_clr_o[i] = fc_hit[i] | (w1c_flg & wdata_i[i]);
  end

  assign ovf_clr_o = op_i.wr & sel_ovf_o & w1c_ok & wdata_i[DW-1];

  // R5: no write-one-to-clear without an enable
  a_r5_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tmr_en_i && !pacc_en_i && !fast_clr_i) |-> (ch_clr_o == '0 && !ovf_clr_o));

  // R7: window accesses inert without fast-clear
  a_r7_no_fc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!fast_clr_i && in_win) |-> (ch_clr_o == '0));

  a_r6_one_ch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(fc_hit));
endmodule

// File: rtl/tflg_flag_bank.sv
module tflg_flag_bank #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] q_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        q_o[i] <= 1'b0;
      else if (set_i[i])  q_o[i] <= 1'b1;  // set wins
      else if (clr_i[i])  q_o[i] <= 1'b0;
    end

    a_r8_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
      set_i[i] |=> q_o[i]);

    a_r4_fall_needs_clr: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(q_o[i]) |-> $past(clr_i[i]));
  end
endmodule

// File: rtl/tflg_irq.sv
module tflg_irq #(
  parameter int NCH = 8
) (
  input  logic [NCH-1:0] ch_flg_i,
  input  logic [NCH-1:0] ch_en_i,
  input  logic           ovf_flg_i,
  input  logic           ovf_en_i,
  output logic           irq_o
);
  assign irq_o = (|(ch_flg_i & ch_en_i)) | (ovf_flg_i & ovf_en_i);
endmodule

// File: rtl/tflg_ctrl.sv
module tflg_ctrl #(
  parameter int NCH = 8,
  parameter int AW  = 5,
  parameter int DW  = 8
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [AW-1:0]  addr_i,
  input  logic           rd_i,
  input  logic           wr_i,
  input  logic [DW-1:0]  wdata_i,
  output logic [DW-1:0]  rdata_o,
  input  logic [NCH-1:0] ch_evt_i,
  input  logic           ovf_evt_i,
  input  logic           tmr_en_i,
  input  logic           pacc_en_i,
  input  logic           fast_clr_i,
  input  logic [NCH-1:0] ch_is_cmp_i,
  input  logic [NCH-1:0] ch_irq_en_i,
  input  logic           ovf_irq_en_i,
  output logic           irq_o
);
  import tflg_pkg::*;

  bus_op_t        op;
  logic           sel_flg;
  logic           sel_ovf;
  logic [NCH-1:0] ch_clr;
  logic           ovf_clr;
  logic [NCH-1:0] ch_q;
  logic           ovf_q;
  logic [DW-1:0]  rd_ch;
  logic [DW-1:0]  rd_ovf;

  assign op.rd = rd_i;
  assign op.wr = wr_i;

  tflg_decode #(.NCH(NCH), .AW(AW), .DW(DW)) u_dec (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .addr_i      (addr_i),
    .op_i        (op),
    .wdata_i     (wdata_i),
    .tmr_en_i    (tmr_en_i),
    .pacc_en_i   (pacc_en_i),
    .fast_clr_i  (fast_clr_i),
    .ch_is_cmp_i (ch_is_cmp_i),
    .sel_flg_o   (sel_flg),
    .sel_ovf_o   (sel_ovf),
    .ch_clr_o    (ch_clr),
    .ovf_clr_o   (ovf_clr)
  );

  tflg_flag_bank #(.W(NCH)) u_ch (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (ch_evt_i),
    .clr_i  (ch_clr),
    .q_o    (ch_q)
  );

  tflg_flag_bank #(.W(1)) u_ovf (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (ovf_evt_i),
    .clr_i  (ovf_clr),
    .q_o    (ovf_q)
  );

  tflg_irq #(.NCH(NCH)) u_irq (
    .ch_flg_i  (ch_q),
    .ch_en_i   (ch_irq_en_i),
    .ovf_flg_i (ovf_q),
    .ovf_en_i  (ovf_irq_en_i),
    .irq_o     (irq_o)
  );

  always_comb begin
    rd_ch            = '0;
    rd_ch[NCH-1:0]   = ch_q;
    rd_ovf           = '0;
    rd_ovf[DW-1]     = ovf_q;
  end

  always_comb begin
    if (sel_flg)      rdata_o = rd_ch;
    else if (sel_ovf) rdata_o = rd_ovf;
    else              rdata_o = '0;
  end

  a_r2_ovf_low_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (32'(addr_i) == 32'(OVF_OFF)) |-> (rdata_o[DW-2:0] == '0));

  a_r9_irq_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ch_q == '0 && !ovf_q) |-> !irq_o);

  a_r9_irq_hit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((|(ch_q & ch_irq_en_i)) || (ovf_q && ovf_irq_en_i)) |-> irq_o);

  a_r3_ovf_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_evt_i |=> ovf_q);
endmodule

// File: tb/tb_tflg_ctrl.sv
module tb_tflg_ctrl;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [4:0] addr = '0;
  logic       rd = 1'b0, wr = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic [7:0] ch_evt = '0;
  logic       ovf_evt = 1'b0;
  logic       ten = 1'b0, pen = 1'b0, fc = 1'b0;
  logic [7:0] is_cmp = '0, ch_en = '0;
  logic       ovf_en = 1'b0;
  logic       irq;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic [7:0] exp_ch = '0;
  logic       exp_ovf = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tflg_ctrl dut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .rd_i(rd), .wr_i(wr),
    .wdata_i(wdata), .rdata_o(rdata), .ch_evt_i(ch_evt), .ovf_evt_i(ovf_evt),
    .tmr_en_i(ten), .pacc_en_i(pen), .fast_clr_i(fc), .ch_is_cmp_i(is_cmp),
    .ch_irq_en_i(ch_en), .ovf_irq_en_i(ovf_en), .irq_o(irq)
  );

  function automatic logic [7:0] nxt_ch(logic [7:0] cur, logic [7:0] ev,
      logic [4:0] a, logic r, logic w, logic [7:0] wd, logic te, logic pe,
      logic f, logic [7:0] cmp);
    logic [7:0] clr = '0;
    if (w && a == 5'h0E && (te || pe)) clr = wd;
    if (f && a[4]) begin
      if (cmp[a[3:1]] ? w : r) clr[a[3:1]] = 1'b1;
    end
    return ev | (cur & ~clr);
  endfunction

  function automatic logic nxt_ovf(logic cur, logic ev, logic [4:0] a,
      logic w, logic [7:0] wd, logic te, logic pe);
    return ev | (cur & !(w && a == 5'h0F && (te || pe) && wd[7]));
  endfunction

  function automatic logic exp_irq();
    return (|(exp_ch & ch_en)) | (exp_ovf & ovf_en);
  endfunction

  task automatic check(input bit ok, input string req, input logic [7:0] act,
                       input logic [7:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  // one bus/event cycle; strobes drop after the edge
  task automatic apply(input logic [4:0] a, input logic r, input logic w,
                       input logic [7:0] wd, input logic [7:0] ev, input logic ov);
    addr = a; rd = r; wr = w; wdata = wd; ch_evt = ev; ovf_evt = ov;
    exp_ch  = nxt_ch(exp_ch, ev, a, r, w, wd, ten, pen, fc, is_cmp);
    exp_ovf = nxt_ovf(exp_ovf, ov, a, w, wd, ten, pen);
    @(posedge clk); @(negedge clk);
    rd = 1'b0; wr = 1'b0; ch_evt = '0; ovf_evt = 1'b0;
  endtask

  task automatic peek(input string req);
    addr = 5'h0E; #1;
    check(rdata == exp_ch, req, rdata, exp_ch);
    check(irq == exp_irq(), "R9", {7'b0, irq}, {7'b0, exp_irq()});
    addr = 5'h0F; #1;
    check(rdata == {exp_ovf, 7'b0}, req, rdata, {exp_ovf, 7'b0});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    ch_en = 8'hFF; ovf_en = 1'b1;
    peek("R1");
    rst_n = 1'b1;
    @(negedge clk);
    peek("R1");

    // R3: events set flags
    apply(5'h00, 0, 0, 8'h00, 8'hA5, 1'b1);
    peek("R3");
    // R2: unmapped address reads zero
    addr = 5'h03; #1; check(rdata == 8'h00, "R2", rdata, 8'h00);
    addr = 5'h12; #1; check(rdata == 8'h00, "R2", rdata, 8'h00);

    // R5: clears blocked with both enables low
    ten = 0; pen = 0; fc = 0;
    apply(5'h0E, 0, 1, 8'hFF, 8'h00, 1'b0);
    apply(5'h0F, 0, 1, 8'h80, 8'h00, 1'b0);
    peek("R5");
    check(exp_ch == 8'hA5, "R5", exp_ch, 8'hA5);

    // R4: write zero leaves flags, ones clear (pulse accumulator enable only)
    pen = 1;
    apply(5'h0E, 0, 1, 8'h00, 8'h00, 1'b0);
    peek("R4");
    apply(5'h0E, 0, 1, 8'h05, 8'h00, 1'b0);
    peek("R4");
    apply(5'h0F, 0, 1, 8'h7F, 8'h00, 1'b0);
    peek("R4");
    apply(5'h0F, 0, 1, 8'h80, 8'h00, 1'b0);
    peek("R4");
    pen = 0;

    // R7: window access without fast-clear
    apply(5'h00, 0, 0, 8'h00, 8'hFF, 1'b0);
    is_cmp = 8'hF0;
    apply(5'h10, 1, 0, 8'h00, 8'h00, 1'b0);
    apply(5'h1E, 0, 1, 8'h00, 8'h00, 1'b0);
    peek("R7");

    // R6: fast clear both directions
    fc = 1;
    apply(5'h13, 1, 0, 8'h00, 8'h00, 1'b0);  // ch1 capture read
    apply(5'h1C, 0, 1, 8'h00, 8'h00, 1'b0);  // ch6 compare write
    apply(5'h14, 0, 1, 8'h00, 8'h00, 1'b0);  // ch2 capture write: no clear
    apply(5'h1F, 1, 0, 8'h00, 8'h00, 1'b0);  // ch7 compare read: no clear
    peek("R6");
    check(exp_ch == 8'hBD, "R6", exp_ch, 8'hBD);

    // R8: set beats simultaneous clear
    ten = 1;
    apply(5'h0E, 0, 1, 8'h80, 8'h80, 1'b0);
    apply(5'h0F, 0, 1, 8'h80, 8'h00, 1'b1);
    apply(5'h11, 1, 0, 8'h00, 8'h01, 1'b0);
    peek("R8");

    // R9: masked interrupt
    apply(5'h0E, 0, 1, 8'hFF, 8'h00, 1'b0);
    apply(5'h0F, 0, 1, 8'h80, 8'h00, 1'b0);
    apply(5'h00, 0, 0, 8'h00, 8'h08, 1'b0);
    ch_en = 8'hF7; ovf_en = 1'b0;
    peek("R9");
    ch_en = 8'h08;
    peek("R9");

    // random mix, checked against the model (R2, R3, R4, R5, R6, R7, R8, R9)
    for (int i = 0; i < 400; i++) begin
      logic [4:0] a;
      int op;
      ten = ($urandom % 3) == 0;
      pen = ($urandom % 3) == 0;
      fc  = ($urandom % 2) == 0;
      is_cmp = 8'($urandom);
      ch_en  = 8'($urandom);
      ovf_en = 1'($urandom);
      case ($urandom % 4)
        0: a = 5'h0E;
        1: a = 5'h0F;
        2: a = 5'h10 | 5'($urandom % 16);
        default: a = 5'($urandom);
      endcase
      op = $urandom % 3;
      apply(a, op == 1, op == 2, 8'($urandom),
            (($urandom % 4) == 0) ? 8'($urandom) : 8'h00, ($urandom % 5) == 0);
      peek("R6");
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule